// File: doc/BRIEF.md
# Multi-Channel Key Interrupt Controller

This block watches a bank of key input pins and condenses activity on them into one shared interrupt request. Each pin is brought into the clock domain by a short synchronizer. A valid transition is detected by comparing the newest synchronized sample with the one before it. A single polarity bit selects whether a falling or a rising transition counts as valid, and a per-channel enable mask chooses which pins take part.

There are two operating modes. In plain mode nothing is stored. The interrupt pulses when a valid transition appears on an enabled pin while every other enabled pin is inactive. In latched mode every valid transition sets a sticky per-channel pending bit, which software clears by writing ones to it. The interrupt pulses when the set of enabled pending bits first becomes non-empty. After each clear that leaves other pending bits set, the interrupt fires again one clock later, so software that services one channel per interrupt never loses an event.

A small register port gives access to the settings and the pending bits. Address 0 is control: bit 0 selects latched mode and bit 1 selects rising polarity. Address 1 is the enable mask, address 2 holds the pending bits and is write-one-to-clear, and address 3 reads as zero.

Top module: `keyirq_ctrl`

## Requirements
- R1: After reset, `irq` is 0 and reads of addresses 0, 1, 2 and 3 all return 0.
- R2: When control bit 1 is 0, only a high-to-low pin change is valid. When it is 1, only a low-to-high change is valid. The opposite change causes no interrupt and leaves the pending bits unchanged.
- R3: A channel whose enable bit (address 1, bit i for channel i) is 0 never sets its pending bit and never causes an interrupt. In plain mode, an active level on a disabled pin does not stop another enabled channel from interrupting.
- R4: In latched mode (control bit 0 = 1), a valid change on enabled channel i sets bit i of address 2. If no other enabled pending bit was set, `irq` is high for exactly one cycle, sampled after the fourth rising clock edge that follows the pin change.
- R5: Writing to address 2 clears every pending bit written as 1 and leaves every bit written as 0 unchanged. Pending bits are never cleared by hardware while latched mode is on.
- R6: If a valid change on channel i and a write of 1 to bit i of address 2 take effect at the same clock edge, bit i stays set.
- R7: When a write to address 2 clears at least one pending bit and some enabled pending bit is still set afterwards, `irq` pulses for one cycle in the cycle after the clock edge that performed the clear. If no enabled pending bit remains, no pulse follows.
- R8: While an enabled pending bit is set, further valid changes on other channels set their bits without a new pulse. A pin that is held at its active level causes no further interrupt.
- R9: In plain mode (control bit 0 = 0), address 2 reads 0. `irq` pulses for one cycle after the third rising edge following a valid change, but only if every other enabled pin was inactive just before that change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| key_in | input | 8 | Key input pins, asynchronous to clk |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 8 | Register read data, combinational from rd_addr |
| irq | output | 1 | Shared interrupt request, one-cycle pulse |

## Verification
A pin change lands in the pending register after three clock edges. The interrupt follows after the third edge in plain mode and the fourth edge in latched mode. A clearing write leads to a pulse one edge after the edge that performs the clear. Every stimulus is therefore applied just after a rising edge. The bench then samples `irq` at each of the following eight falling edges, recording the index of the first high sample and the number of high samples, and compares them with 3, 4 or 2 for a pulse and with no high sample where none is due. The same-edge race between a pending-bit set and a clear is staged by starting the write two edges after the pin change, so that both act at the third edge.

// File: rtl/keyirq_pkg.sv
package keyirq_pkg;

  localparam int REG_ADDR_W    = 2;
  localparam int CTRL_MODE_BIT = 0;
  localparam int CTRL_RISE_BIT = 1;

  typedef enum logic [REG_ADDR_W-1:0] {
    RA_CTRL = 2'd0,
    RA_EN   = 2'd1,
    RA_PEND = 2'd2,
    RA_RSVD = 2'd3
  } reg_addr_e;

endpackage

// File: rtl/keyirq_edge.sv
module keyirq_edge #(
  parameter int N_CH        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_CH-1:0] pin_i,
  input  logic            rise_i,
  output logic [N_CH-1:0] act_prev_o,
  output logic [N_CH-1:0] edge_o
);

  localparam int HIST_W = SYNC_STAGES + 1;

  logic [N_CH-1:0] act_now;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    logic [HIST_W-1:0] hist_q;
    logic [HIST_W-1:0] hist_d;

    always_comb begin
      hist_d = {hist_q[HIST_W-2:0], pin_i[g]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hist_q <= '0;
      end else begin
        hist_q <= hist_d;
      end
    end

    // the polarity is applied to both taps, so a polarity change alone is no edge
    assign act_now[g]    = hist_q[SYNC_STAGES-1] ^ ~rise_i;
    assign act_prev_o[g] = hist_q[SYNC_STAGES]   ^ ~rise_i;
    assign edge_o[g]     = act_now[g] & ~act_prev_o[g];

    AST_EDGE_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
      edge_o[g] |=> (!edge_o[g] || !$stable(rise_i))); // R8
  end

endmodule

// File: rtl/keyirq_flags.sv
module keyirq_flags #(
  parameter int N_CH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_i,
  input  logic [N_CH-1:0] en_i,
  input  logic [N_CH-1:0] edge_i,
  input  logic [N_CH-1:0] clr_i,
  output logic [N_CH-1:0] flags_o,
  output logic            clr_hit_o
);

  logic [N_CH-1:0] flags_q;
  logic [N_CH-1:0] flags_d;
  logic [N_CH-1:0] set_vec;
  logic [N_CH-1:0] keep_vec;

  always_comb begin
    set_vec  = edge_i & en_i;
    keep_vec = flags_q & ~clr_i;
    if (mode_i) begin
      flags_d = keep_vec | set_vec;   // a set wins over a clear on the same edge
    end else begin
      flags_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else begin
      flags_q <= flags_d;
    end
  end

  assign flags_o   = flags_q;
  assign clr_hit_o = |(clr_i & flags_q);

  AST_DISABLED_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags_q & ~$past(flags_q)) & ~$past(en_i)) == '0); // R3
  AST_PLAIN_NO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_i |=> (flags_q == '0)); // R9
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    mode_i |=> ((($past(flags_q) & ~$past(clr_i)) & ~flags_q) == '0)); // R5

endmodule

// File: rtl/keyirq_req.sv
module keyirq_req #(
  parameter int N_CH = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mode_i,
  input  logic [N_CH-1:0] en_i,
  input  logic [N_CH-1:0] flags_i,
  input  logic            clr_hit_i,
  input  logic [N_CH-1:0] edge_i,
  input  logic [N_CH-1:0] act_prev_i,
  output logic            irq_o
);

  logic any_pend;
  logic any_q;
  logic any_d;
  logic clr_pend_q;
  logic clr_pend_d;
  logic irq_q;
  logic irq_d;
  logic latch_req;
  logic plain_req;

  always_comb begin
    any_pend   = |(flags_i & en_i);
    latch_req  = (any_pend & ~any_q) | (clr_pend_q & any_pend);
    plain_req  = (|(edge_i & en_i)) & ~(|(act_prev_i & en_i));
    irq_d      = mode_i ? latch_req : plain_req;
    any_d      = any_pend;
    clr_pend_d = mode_i & clr_hit_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      any_q      <= 1'b0;
      clr_pend_q <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      any_q      <= any_d;
      clr_pend_q <= clr_pend_d;
      irq_q      <= irq_d;
    end
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/keyirq_ctrl.sv
module keyirq_ctrl
  import keyirq_pkg::*;
#(
  parameter int N_CH        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_CH-1:0]       key_in,
  input  logic                  wr_en,
  input  logic [REG_ADDR_W-1:0] wr_addr,
  input  logic [N_CH-1:0]       wr_data,
  input  logic [REG_ADDR_W-1:0] rd_addr,
  output logic [N_CH-1:0]       rd_data,
  output logic                  irq
);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       srst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[0], 1'b1};
    end
  end

  assign srst_n = rst_pipe_q[1];

  // configuration registers
  reg_addr_e       wsel;
  reg_addr_e       rsel;
  logic            ctrl_we;
  logic            en_we;
  logic            mode_q;
  logic            mode_d;
  logic            rise_q;
  logic            rise_d;
  logic [N_CH-1:0] en_q;
  logic [N_CH-1:0] en_d;
  logic [N_CH-1:0] clr_mask;

  assign wsel = reg_addr_e'(wr_addr);
  assign rsel = reg_addr_e'(rd_addr);

  always_comb begin
    ctrl_we  = wr_en && (wsel == RA_CTRL);
    en_we    = wr_en && (wsel == RA_EN);
    mode_d   = wr_data[CTRL_MODE_BIT];
    rise_d   = wr_data[CTRL_RISE_BIT];
    en_d     = wr_data;
    clr_mask = (wr_en && (wsel == RA_PEND)) ? wr_data : '0;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      mode_q <= 1'b0;
      rise_q <= 1'b0;
    end else if (ctrl_we) begin
      mode_q <= mode_d;
      rise_q <= rise_d;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      en_q <= '0;
    end else if (en_we) begin
      en_q <= en_d;
    end
  end

  // datapath
  logic [N_CH-1:0] edge_vec;
  logic [N_CH-1:0] act_prev;
  logic [N_CH-1:0] flags;
  logic            clr_hit;

  keyirq_edge #(.N_CH(N_CH), .SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk        (clk),
    .rst_n      (srst_n),
    .pin_i      (key_in),
    .rise_i     (rise_q),
    .act_prev_o (act_prev),
    .edge_o     (edge_vec)
  );

  keyirq_flags #(.N_CH(N_CH)) u_flags (
    .clk       (clk),
    .rst_n     (srst_n),
    .mode_i    (mode_q),
    .en_i      (en_q),
    .edge_i    (edge_vec),
    .clr_i     (clr_mask),
    .flags_o   (flags),
    .clr_hit_o (clr_hit)
  );

  keyirq_req #(.N_CH(N_CH)) u_req (
    .clk        (clk),
    .rst_n      (srst_n),
    .mode_i     (mode_q),
    .en_i       (en_q),
    .flags_i    (flags),
    .clr_hit_i  (clr_hit),
    .edge_i     (edge_vec),
    .act_prev_i (act_prev),
    .irq_o      (irq)
  );

  // read mux
  always_comb begin
    rd_data = '0;
    case (rsel)
      RA_CTRL: begin
        rd_data[CTRL_MODE_BIT] = mode_q;
        rd_data[CTRL_RISE_BIT] = rise_q;
      end
      RA_EN:   rd_data = en_q;
      RA_PEND: rd_data = flags;
      default: rd_data = '0;
    endcase
  end

  logic pend_any;
  assign pend_any = |(flags & en_q);

  AST_FIRST_PEND_IRQ: assert property (@(posedge clk) disable iff (!srst_n)
    (mode_q && $rose(pend_any)) |=> irq); // R4
  AST_REISSUE_AFTER_CLR: assert property (@(posedge clk) disable iff (!srst_n)
    ($past(clr_hit) && pend_any && mode_q) |=> irq); // R7
  AST_PLAIN_SINGLE: assert property (@(posedge clk) disable iff (!srst_n)
    (irq && !mode_q && !$past(mode_q)) |=> !irq); // R9

endmodule

// File: tb/keyirq_ctrl_bench.sv
module keyirq_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] key_in;
  logic       wr_en;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic [1:0] rd_addr;
  logic [7:0] rd_data;
  logic       irq;

  int n_run  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  keyirq_ctrl u_keyirq_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .key_in  (key_in),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (rd_addr),
    .rd_data (rd_data),
    .irq     (irq)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_addr = a;
    #2;
    d = rd_data;
  endtask

  // called 1 ns after the edge that starts the stimulus
  task automatic watch(output int first, output int cnt);
    first = -1;
    cnt   = 0;
    for (int k = 1; k <= 8; k++) begin
      @(posedge clk); #1;
      wr_en = 1'b0;
      @(negedge clk);
      if (irq) begin
        cnt++;
        if (first < 0) first = k;
      end
    end
  endtask

  task automatic pin_go(input logic [7:0] v, output int first, output int cnt);
    @(posedge clk); #1;
    key_in = v;
    watch(first, cnt);
  endtask

  task automatic clr_go(input logic [7:0] d, output int first, output int cnt);
    @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = 2'd2; wr_data = d;
    watch(first, cnt);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] rv;
    logic [7:0] idle;
    logic [7:0] act;
    int f;
    int n;
    int exp_f;
    int exp_n;
    int exp_fl;
    string lab;

    rst_n = 1'b0; key_in = 8'hFF; wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (5) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R1 reset state
    @(negedge clk);
    check("R1", "irq after reset", int'(irq), 0);
    for (int a = 0; a < 4; a++) begin
      reg_rd(a[1:0], rv);
      check("R1", "register after reset", int'(rv), 0);
    end

    // sweep: mode x polarity x channel x enable
    for (int m = 0; m < 2; m++) begin
      for (int r = 0; r < 2; r++) begin
        for (int c = 0; c < 8; c++) begin
          for (int e = 0; e < 2; e++) begin
            idle = (r != 0) ? 8'h00 : 8'hFF;
            act  = idle ^ (8'h01 << c);
            reg_wr(2'd1, 8'h00);
            reg_wr(2'd0, {6'b0, r[0], m[0]});
            @(posedge clk); #1; key_in = idle;
            repeat (6) @(posedge clk);
            reg_wr(2'd2, 8'hFF);
            reg_wr(2'd1, (e != 0) ? (8'h01 << c) : 8'h00);
            lab    = (e == 0) ? "R3" : ((m != 0) ? "R4" : "R9");
            exp_f  = (e == 0) ? -1 : ((m != 0) ? 4 : 3);
            exp_n  = (e == 0) ? 0 : 1;
            exp_fl = (e != 0 && m != 0) ? (1 << c) : 0;
            pin_go(act, f, n);
            check(lab, "first irq cycle", f, exp_f);
            check(lab, "irq pulse count", n, exp_n);
            reg_rd(2'd2, rv);
            check(lab, "pending bits", int'(rv), exp_fl);
            // opposite transition is not a valid edge
            pin_go(idle, f, n);
            check("R2", "pulses on opposite change", n, 0);
            reg_rd(2'd2, rv);
            check("R2", "pending after opposite change", int'(rv), exp_fl);
          end
        end
      end
    end

    // latched mode, falling polarity, all enabled: multi-channel reissue
    reg_wr(2'd1, 8'h00);
    reg_wr(2'd0, 8'h01);
    @(posedge clk); #1; key_in = 8'hFF;
    repeat (6) @(posedge clk);
    reg_wr(2'd2, 8'hFF);
    reg_wr(2'd1, 8'hFF);
    pin_go(8'hFE, f, n);
    check("R4", "ch0 first irq", f, 4);
    check("R4", "ch0 pulse count", n, 1);
    pin_go(8'hBC, f, n);
    check("R8", "pulses while pending", n, 0);
    reg_rd(2'd2, rv);
    check("R8", "pending after ch1 ch6", int'(rv), 8'h43);
    clr_go(8'h01, f, n);
    check("R7", "reissue after clear ch0", f, 2);
    check("R7", "reissue count ch0", n, 1);
    reg_rd(2'd2, rv);
    check("R5", "partial clear ch0", int'(rv), 8'h42);
    clr_go(8'h02, f, n);
    check("R7", "reissue after clear ch1", f, 2);
    check("R7", "reissue count ch1", n, 1);
    reg_rd(2'd2, rv);
    check("R8", "held ch6 keeps only its bit", int'(rv), 8'h40);
    clr_go(8'h40, f, n);
    check("R7", "no reissue when none pending", n, 0);
    pin_go(8'hBC, f, n);
    check("R8", "held low level no retrigger", n, 0);
    reg_rd(2'd2, rv);
    check("R8", "held low no new pending", int'(rv), 0);

    // edge and clear at the same edge
    pin_go(8'hFF, f, n);
    pin_go(8'hFB, f, n);
    check("R4", "ch2 pulse", n, 1);
    pin_go(8'hFF, f, n);
    @(posedge clk); #1; key_in = 8'hFB;
    @(posedge clk); @(posedge clk); #1;
    wr_en = 1'b1; wr_addr = 2'd2; wr_data = 8'h04;
    @(posedge clk); #1; wr_en = 1'b0;
    reg_rd(2'd2, rv);
    check("R6", "set wins over clear", int'(rv), 8'h04);
    reg_wr(2'd2, 8'h00);
    reg_rd(2'd2, rv);
    check("R5", "zero write keeps bit", int'(rv), 8'h04);
    reg_wr(2'd2, 8'h04);
    reg_rd(2'd2, rv);
    check("R5", "one write clears bit", int'(rv), 0);

    // plain mode ordering
    reg_wr(2'd0, 8'h00);
    pin_go(8'hFF, f, n);
    pin_go(8'hFE, f, n);
    check("R9", "plain first edge", f, 3);
    check("R9", "plain pulse count", n, 1);
    pin_go(8'hFC, f, n);
    check("R9", "plain edge while other active", n, 0);
    reg_rd(2'd2, rv);
    check("R9", "plain no pending bits", int'(rv), 0);
    pin_go(8'hFF, f, n);
    pin_go(8'hF7, f, n);
    check("R9", "plain after release", f, 3);

    // disabled input held active does not block plain mode
    pin_go(8'hFF, f, n);
    reg_wr(2'd1, 8'hFE);
    pin_go(8'hFE, f, n);
    check("R3", "disabled ch0 edge", n, 0);
    pin_go(8'hFC, f, n);
    check("R3", "ch1 with disabled ch0 low", f, 3);
    check("R3", "ch1 pulse count", n, 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule